// File: doc/BRIEF.md
# I2C Target with Paired-Register Pointer

This block is an I2C target holding eight 8-bit registers grouped as four pairs: input port (indices 0 and 1), output port (2 and 3), polarity inversion (4 and 5) and configuration (6 and 7). The system clock oversamples SCL and SDA. The block detects START and STOP, matches a 7-bit address and takes a command byte that sets a register pointer. It then accepts write data or shifts read data out MSB first.

The pointer does not count through the map. After every data byte, in either direction, it moves to the other register of the same pair. A host can therefore stream bytes into one pair for as long as it likes. The output and configuration pairs are visible as parallel outputs. Reads of the input pair return the live pin values, each bit inverted where the matching polarity bit is set.

The finite-state machine has these states: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_CMD`, `ST_CMD_ACK`, `ST_WR_BYTE`, `ST_WR_ACK`, `ST_RD_BYTE`, `ST_RD_ACK`.

Transitions:
- A START from any state leads to `ST_ADDR`. A STOP from any state leads to `ST_IDLE`.
- From `ST_ADDR`, after eight bits, a matching address leads to `ST_ADDR_ACK`. Any other address leads to `ST_IDLE`.
- From `ST_ADDR_ACK`, at the end of the acknowledge bit, the machine goes to `ST_CMD` for a write or `ST_RD_BYTE` for a read. The read byte is loaded at that point.
- `ST_CMD` goes to `ST_CMD_ACK`, which goes to `ST_WR_BYTE`.
- `ST_WR_BYTE` goes to `ST_WR_ACK`, and the write happens there. `ST_WR_ACK` goes back to `ST_WR_BYTE`.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits. On a host ACK, `ST_RD_ACK` returns to `ST_RD_BYTE` with the next byte loaded. On a host NACK it goes to `ST_IDLE`.

Top module: `i2c_pair_regfile`

## Requirements
- R1: After reset, `out_val` and `cfg_val` read 16'hFFFF, both polarity registers (indices 4 and 5) read 8'h00, and `sda_oe` is 0.
- R2: When the address byte's upper seven bits equal `DEV_ADDR`, the block acknowledges it by setting `sda_oe` to 1 (pulling SDA low) during the ninth clock. Bit 0 = 0 selects a write and bit 0 = 1 selects a read. Each command byte and each write data byte is acknowledged the same way.
- R3: An address that does not match gets no acknowledge. Every following byte is ignored, with no acknowledge and no register change, until the next START.
- R4: Bits [2:0] of the command byte load the register pointer, and the upper bits are ignored. Index 2 maps to `out_val[7:0]` and index 3 to `out_val[15:8]`. Index 6 maps to `cfg_val[7:0]` and index 7 to `cfg_val[15:8]`.
- R5: After every data byte, written or read, the pointer flips its bit 0. Writing first to index 3 sends the next byte to index 2.
- R6: One transaction may carry any number of data bytes. They keep alternating within the selected pair.
- R7: Writes to indices 0 and 1 are acknowledged and discarded.
- R8: Reading index 0 returns `pins_in[7:0]` XOR register 4, and reading index 1 returns `pins_in[15:8]` XOR register 5. Other indices return their stored byte. All bytes are sent MSB first.
- R9: A STOP at any point returns the block to idle and drops a partly received byte. A repeated START begins a new address phase, and the pointer keeps its value across it.
- R10: After the host NACKs a read byte, the block releases SDA and drives nothing until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level, as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| pins_in | input | 16 | Port pin levels, returned on reads of indices 0 and 1 |
| out_val | output | 16 | Output-pair registers {index 3, index 2} |
| cfg_val | output | 16 | Configuration-pair registers {index 7, index 6} |

## Verification
The assertions assume that SCL and SDA each stay stable for several system clocks around every edge, so that the synchronised copies show START, STOP, rising and falling edges as separate events. They also assume that SDA changes only while SCL is low, except when a START or STOP is meant. The stimulus holds every bus level for eight system clocks per quarter bit and only moves SDA during the low half of SCL. It keeps `pins_in` constant while a read byte is being shifted out.

// File: rtl/i2cpr_pkg.sv
package i2cpr_pkg;
    localparam int REG_BITS = 8;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } fsm_state_t;
endpackage

// File: rtl/i2cpr_line_sync.sv
module i2cpr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign sda_lvl   = sda_s;
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cpr_regfile.sv
module i2cpr_regfile
    import i2cpr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [REG_BITS-1:0]   wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    input  logic [2*REG_BITS-1:0] pins_in,
    output logic [REG_BITS-1:0]   rd_data,
    output logic [2*REG_BITS-1:0] out_val,
    output logic [2*REG_BITS-1:0] cfg_val
);
    localparam int FIRST_RW = 2;
    localparam int POL_LO   = 4;
    localparam int POL_HI   = 5;

    logic [REG_BITS-1:0] regs_q [FIRST_RW:NUM_REGS-1];

    for (genvar i = FIRST_RW; i < NUM_REGS; i++) begin : g_reg
        localparam logic [REG_BITS-1:0] RST_VAL =
            (i == POL_LO || i == POL_HI) ? '0 : '1;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs_q[i] <= RST_VAL;
            else if (wr_en && wr_idx == IDX_W'(i))
                regs_q[i] <= wr_data;
        end
    end

    always_comb begin
        if (rd_idx[IDX_W-1:1] == '0) begin
            if (rd_idx[0])
                rd_data = pins_in[2*REG_BITS-1:REG_BITS] ^ regs_q[POL_HI];
            else
                rd_data = pins_in[REG_BITS-1:0] ^ regs_q[POL_LO];
        end else begin
            rd_data = regs_q[rd_idx];
        end
    end

    assign out_val = {regs_q[3], regs_q[2]};
    assign cfg_val = {regs_q[7], regs_q[6]};

    // R7: a write aimed at the input pair leaves every stored register untouched
    a_r7_input_pair_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx[IDX_W-1:1] == '0) |=>
            ($stable(out_val) && $stable(cfg_val) &&
             $stable(regs_q[POL_LO]) && $stable(regs_q[POL_HI])));
endmodule

// File: rtl/i2cpr_fsm.sv
module i2cpr_fsm
    import i2cpr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sda_lvl,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic [REG_BITS-1:0] rd_data,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_idx,
    output logic [REG_BITS-1:0] wr_data,
    output logic [IDX_W-1:0]    rd_idx,
    output logic                sda_oe
);
    localparam int         CNT_W    = $clog2(REG_BITS + 1);
    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(REG_BITS);
    localparam logic [CNT_W-1:0] BITS_LAST = CNT_W'(REG_BITS - 1);
    localparam logic [IDX_W-1:0] PAIR_FLIP = IDX_W'(1);

    fsm_state_t          state, n_state;
    logic [CNT_W-1:0]    cnt, n_cnt;
    logic [REG_BITS-1:0] shreg, n_sh;
    logic [IDX_W-1:0]    ptr, n_ptr;
    logic                rw, n_rw;
    logic                mnack, n_nack;

    always_comb begin
        n_state = state;
        n_cnt   = cnt;
        n_sh    = shreg;
        n_ptr   = ptr;
        n_rw    = rw;
        n_nack  = mnack;
        wr_en   = 1'b0;
        if (start_det) begin
            n_state = ST_ADDR;
            n_cnt   = '0;
        end else if (stop_det) begin
            n_state = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR, ST_CMD, ST_WR_BYTE: begin
                    if (scl_rise && cnt < BITS_FULL) begin
                        n_sh  = {shreg[REG_BITS-2:0], sda_lvl};
                        n_cnt = cnt + CNT_W'(1);
                    end else if (scl_fall && cnt == BITS_FULL) begin
                        n_cnt = '0;
                        if (state == ST_ADDR) begin
                            if (shreg[REG_BITS-1:1] == DEV_ADDR) begin
                                n_rw    = shreg[0];
                                n_state = ST_ADDR_ACK;
                            end else begin
                                n_state = ST_IDLE;
                            end
                        end else if (state == ST_CMD) begin
                            n_ptr   = shreg[IDX_W-1:0];
                            n_state = ST_CMD_ACK;
                        end else begin
                            wr_en   = 1'b1;
                            n_ptr   = ptr ^ PAIR_FLIP;
                            n_state = ST_WR_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        n_cnt = '0;
                        if (rw) begin
                            n_sh    = rd_data;
                            n_ptr   = ptr ^ PAIR_FLIP;
                            n_state = ST_RD_BYTE;
                        end else begin
                            n_state = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        n_cnt   = '0;
                        n_state = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (cnt == BITS_LAST) begin
                            n_cnt   = '0;
                            n_state = ST_RD_ACK;
                        end else begin
                            n_cnt = cnt + CNT_W'(1);
                            n_sh  = {shreg[REG_BITS-2:0], 1'b0};
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        n_nack = sda_lvl;
                    end else if (scl_fall) begin
                        n_cnt = '0;
                        if (!mnack) begin
                            n_sh    = rd_data;
                            n_ptr   = ptr ^ PAIR_FLIP;
                            n_state = ST_RD_BYTE;
                        end else begin
                            n_state = ST_IDLE;
                        end
                    end
                end
                default: n_state = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            ptr   <= '0;
            rw    <= 1'b0;
            mnack <= 1'b0;
        end else begin
            state <= n_state;
            cnt   <= n_cnt;
            shreg <= n_sh;
            ptr   <= n_ptr;
            rw    <= n_rw;
            mnack <= n_nack;
        end
    end

    // output register: drive SDA low for acknowledges and zero read bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sda_oe <= 1'b0;
        else
            sda_oe <= (n_state inside {ST_ADDR_ACK, ST_CMD_ACK, ST_WR_ACK}) ||
                      (n_state == ST_RD_BYTE && !n_sh[REG_BITS-1]);
    end

    assign wr_idx  = ptr;
    assign rd_idx  = ptr;
    assign wr_data = shreg;

    // R2: SDA is only pulled while an acknowledge or a read byte is owed
    a_r2_drive_only_when_owed: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state inside {ST_ADDR_ACK, ST_CMD_ACK, ST_WR_ACK, ST_RD_BYTE}));

    // R3: a foreign address sends the machine idle without an acknowledge
    a_r3_foreign_addr_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && cnt == BITS_FULL &&
         shreg[REG_BITS-1:1] != DEV_ADDR && !start_det && !stop_det)
        |=> (state == ST_IDLE && !sda_oe));

    // R4: command byte low bits become the pointer
    a_r4_cmd_loads_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && scl_fall && cnt == BITS_FULL && !start_det && !stop_det)
        |=> (ptr == $past(shreg[IDX_W-1:0])));

    // R5: each written byte flips the pointer within its pair
    a_r5_pair_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_BYTE && scl_fall && cnt == BITS_FULL && !start_det && !stop_det)
        |=> (ptr == ($past(ptr) ^ PAIR_FLIP)));

    // R9: STOP always lands in idle with SDA released
    a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R10: host NACK releases the line
    a_r10_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_fall && mnack && !start_det && !stop_det)
        |=> (state == ST_IDLE && !sda_oe));
endmodule

// File: rtl/i2c_pair_regfile.sv
module i2c_pair_regfile
    import i2cpr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h24,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [2*REG_BITS-1:0] pins_in,
    output logic [2*REG_BITS-1:0] out_val,
    output logic [2*REG_BITS-1:0] cfg_val
);
    logic                sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic                wr_en;
    logic [IDX_W-1:0]    wr_idx, rd_idx;
    logic [REG_BITS-1:0] wr_data, rd_data;

    i2cpr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cpr_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .sda_oe    (sda_oe)
    );

    i2cpr_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .pins_in (pins_in),
        .rd_data (rd_data),
        .out_val (out_val),
        .cfg_val (cfg_val)
    );
endmodule

// File: tb/sim_i2c_pair_regfile.sv
`timescale 1ns/1ps
module sim_i2c_pair_regfile;
    localparam logic [6:0] DEV = 7'h24;
    localparam logic [6:0] FOREIGN = 7'h25;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [15:0] pins = 16'h0000;
    logic        sda_oe;
    logic [15:0] out_val, cfg_val;
    wire         sda_line = m_sda & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_pair_regfile #(.DEV_ADDR(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .pins_in(pins), .out_val(out_val), .cfg_val(cfg_val)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;
    logic [7:0] mreg [8];
    int mptr = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // reference model compared on every clock while no byte is in flight
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R5 out pair", {16'h0, out_val}, {16'h0, mreg[3], mreg[2]});
            chk("R4 cfg pair", {16'h0, cfg_val}, {16'h0, mreg[7], mreg[6]});
        end
    end

    initial begin
        repeat (150000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic v);
        m_sda = v; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic v);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        v = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        logic v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(v);
        acked = !v;
    endtask

    task automatic rd_byte(output logic [7:0] b, input bit last);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(v);
            b[i] = v;
        end
        send_bit(last);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] cmd,
                            input logic [7:0] data[$], input bit exp_ack, input string req);
        bit ack;
        bus_start();
        wr_byte({a, 1'b0}, ack);
        chk(req, {31'h0, ack}, {31'h0, exp_ack});
        wr_byte(cmd, ack);
        chk(req, {31'h0, ack}, {31'h0, exp_ack});
        if (exp_ack) mptr = int'(cmd[2:0]);
        foreach (data[k]) begin
            cmp_en = 1'b0;
            wr_byte(data[k], ack);
            chk(req, {31'h0, ack}, {31'h0, exp_ack});
            if (exp_ack) begin
                if (mptr >= 2) mreg[mptr] = data[k];
                mptr = mptr ^ 1;
            end
            cmp_en = 1'b1;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] cmd, input int n, input string req);
        bit ack;
        logic [7:0] v, e;
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        chk("R2", {31'h0, ack}, 32'h1);
        wr_byte(cmd, ack);
        chk("R2", {31'h0, ack}, 32'h1);
        mptr = int'(cmd[2:0]);
        bus_start();
        wr_byte({DEV, 1'b1}, ack);
        chk("R2 read addr", {31'h0, ack}, 32'h1);
        for (int k = 0; k < n; k++) begin
            rd_byte(v, k == n - 1);
            if (mptr == 0)      e = pins[7:0] ^ mreg[4];
            else if (mptr == 1) e = pins[15:8] ^ mreg[5];
            else                e = mreg[mptr];
            chk(req, {24'h0, v}, {24'h0, e});
            mptr = mptr ^ 1;
        end
        chk("R10 released", {31'h0, sda_oe}, 32'h0);
        bus_stop();
    endtask

    initial begin
        logic [7:0] q[$];
        bit ack;
        mreg[0] = 8'h00; mreg[1] = 8'h00;
        mreg[2] = 8'hFF; mreg[3] = 8'hFF;
        mreg[4] = 8'h00; mreg[5] = 8'h00;
        mreg[6] = 8'hFF; mreg[7] = 8'hFF;
        wq(5); rst_n = 1'b1; wq(3);
        chk("R1 out", {16'h0, out_val}, 32'hFFFF);
        chk("R1 cfg", {16'h0, cfg_val}, 32'hFFFF);
        chk("R1 oe", {31'h0, sda_oe}, 32'h0);
        cmp_en = 1'b1;

        do_read(8'h04, 2, "R1 polarity");

        q = '{8'hA1, 8'hB2, 8'hC3};
        do_write(DEV, 8'h03, q, 1'b1, "R2");
        chk("R6 three bytes", {16'h0, out_val}, 32'hC3B2);

        q = '{8'h0F, 8'hF0};
        do_write(DEV, 8'h06, q, 1'b1, "R4");
        chk("R4 cfg", {16'h0, cfg_val}, 32'hF00F);

        q = '{8'h55, 8'h66, 8'h77};
        do_write(DEV, 8'h00, q, 1'b1, "R7");
        do_read(8'h04, 2, "R7 polarity kept");

        q = '{8'hAA, 8'h0F};
        do_write(DEV, 8'h04, q, 1'b1, "R8 pol");
        pins = 16'h1234;
        do_read(8'h00, 3, "R8");
        pins = 16'hC081;
        do_read(8'h01, 2, "R8");

        do_read(8'h03, 3, "R5 read toggle");

        q = '{8'h00, 8'h11};
        do_write(FOREIGN, 8'h02, q, 1'b0, "R3");
        chk("R3 out kept", {16'h0, out_val}, 32'hC3B2);

        bus_start();
        wr_byte({FOREIGN, 1'b1}, ack);
        chk("R3 read addr", {31'h0, ack}, 32'h0);
        bus_stop();

        q = '{8'h5A};
        do_write(DEV, 8'hFE, q, 1'b1, "R4 upper bits");
        chk("R4 idx6", {16'h0, cfg_val}, 32'hF05A);

        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h02, ack);
        mptr = 2;
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        wq(4);
        chk("R9 partial dropped", {16'h0, out_val}, 32'hC3B2);
        chk("R9 idle", {31'h0, sda_oe}, 32'h0);

        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        wr_byte(8'h07, ack);
        mptr = 7;
        bus_start();
        wr_byte({DEV, 1'b1}, ack);
        chk("R9 repeated start", {31'h0, ack}, 32'h1);
        begin
            logic [7:0] v;
            rd_byte(v, 1'b1);
            chk("R9 ptr kept", {24'h0, v}, {24'h0, mreg[7]});
        end
        bus_stop();

        q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A};
        do_write(DEV, 8'h02, q, 1'b1, "R6");
        chk("R6 long burst", {16'h0, out_val}, 32'h0A09);

        wq(10);
        finish_run();
    end
endmodule